// File: doc/BRIEF.md
# Table-Based Spectrum Magnitude Estimator

This block turns the complex bins of a finished real-input FFT into 8-bit magnitude estimates without a square root. It steps through the spectrum RAM, fetches the real and imaginary word of each bin, and folds both to non-negative values. It keeps the top four magnitude bits of each as a row and a column index, and reads the magnitude from a 16x16 table that is computed at elaboration. The result is written back over the real word of the same bin, zero-extended. The imaginary words are left as they were.

A real-valued input gives a spectrum that mirrors about bin N/2, so only bins 0 to N/2 are visited. For the two end bins the imaginary part is zero for such an input, and the column index is forced to zero there. A one-cycle `start_i` pulse begins a run and `done_o` pulses once when the run is complete.

The RAM side is a plain memory port and not a stream, so it has no back-pressure. A read request returns data exactly one cycle later, and a write request is taken at the clock edge where it is asserted.

Top module: `lut_spectrum_mag`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o`, `ram_rd_en_o` and `ram_wr_en_o` are all low.
- R2: The real and imaginary words are each replaced by their absolute value before indexing. The value -32768 saturates to 32767, which gives index 15.
- R3: Each index is the absolute 16-bit value shifted right by 11, which is its four most significant magnitude bits.
- R4: The real index selects the table row and the imaginary index selects the column. Entry [i][j] is min(255, floor(16*sqrt(i*i+j*j))). The written word is that 8-bit entry zero-extended to 16 bits.
- R5: Only bins 0 to N/2 are read and written, exactly once each per run. Real words above N/2 and all imaginary words stay unchanged.
- R6: For bin 0 and bin N/2 the column index is 0, whatever the imaginary word holds.
- R7: Bins are processed in ascending order, one every 3 cycles. Each bin is read first and written 2 cycles later at the same address, and consecutive writes are exactly 3 cycles apart.
- R8: `done_o` is a single-cycle pulse in the cycle after the write of bin N/2. `busy_o` is high from the cycle after an accepted start until that write has happened, and low once `done_o` is seen.
- R9: A `start_i` pulse while a run is in progress, or while `done_o` is high, is ignored. It does not restart the run and does not add writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begins a run when the block is idle |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when the run has finished |
| ram_rd_en_o | output | 1 | Read request to the spectrum RAM |
| ram_rd_addr_o | output | ADDR_W | Bin index being read |
| ram_re_i | input | DATA_W | Real word, valid one cycle after the read |
| ram_im_i | input | DATA_W | Imaginary word, valid one cycle after the read |
| ram_wr_en_o | output | 1 | Write request for a real word |
| ram_wr_addr_o | output | ADDR_W | Bin index being written |
| ram_wr_data_o | output | DATA_W | Zero-extended magnitude |

## Verification
Two functions can meet in one cycle. A fresh `start_i` can coincide with a read, calculation or write step of a run that is already going, or with the `done_o` cycle. The bench provokes this by pulsing start in the middle of alternate runs and again in the cycle where done is high. It then judges the outcome from the number of writes, their addresses and spacing, and the count of done pulses. The bench also sweeps all 256 index pairs across mixed signs, so that each table entry is reached through the abs, shift and lookup path.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_CALC,
    ST_WR,
    ST_DONE
  } seq_st_t;

  // floor(sqrt(v)) by restoring bit-by-bit search
  function automatic int unsigned isqrt_floor(input int unsigned v);
    int unsigned r;
    int unsigned t;
    r = 0;
    for (int b = 15; b >= 0; b--) begin
      t = r | (32'd1 << b);
      if (t * t <= v) r = t;
    end
    return r;
  endfunction

  // Table entry: min(2^mag_w - 1, floor(2^(mag_w-idx_w) * sqrt(i^2 + j^2)))
  function automatic int unsigned mag_entry(input int unsigned i, input int unsigned j,
                                            input int unsigned idx_w, input int unsigned mag_w);
    int unsigned scale;
    int unsigned lim;
    int unsigned m;
    scale = 32'd1 << (mag_w - idx_w);
    lim   = (32'd1 << mag_w) - 1;
    m     = isqrt_floor(scale * scale * (i * i + j * j));
    return (m > lim) ? lim : m;
  endfunction

endpackage

// File: rtl/mag_abs_index.sv
module mag_abs_index #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic signed [DATA_W-1:0] val_i,
  input  logic                     zero_i,
  output logic [IDX_W-1:0]         idx_o
);
  localparam int SHIFT = DATA_W - 1 - IDX_W;
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MOST_POS = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0] mag;

  always_comb begin
    if (val_i == MOST_NEG)      mag = MOST_POS;
    else if (val_i[DATA_W-1])   mag = -val_i;
    else                        mag = val_i;
    idx_o = zero_i ? '0 : IDX_W'(mag >> SHIFT);
  end

  always_comb begin
    AST_ABS_SIGN_CLEAR: assert (mag[DATA_W-1] == 1'b0 || $isunknown(val_i)); // R2
  end
endmodule

// File: rtl/mag_lut_rom.sv
module mag_lut_rom #(
  parameter int IDX_W = 4,
  parameter int MAG_W = 8
) (
  input  logic             clk,
  input  logic             en_i,
  input  logic [IDX_W-1:0] row_i,
  input  logic [IDX_W-1:0] col_i,
  output logic [MAG_W-1:0] mag_o
);
  localparam int SIDE  = 1 << IDX_W;
  localparam int DEPTH = SIDE * SIDE;

  logic [MAG_W-1:0] rom [DEPTH];

  for (genvar r = 0; r < SIDE; r++) begin : g_row
    for (genvar c = 0; c < SIDE; c++) begin : g_col
      assign rom[r*SIDE + c] =
        MAG_W'(lsm_pkg::mag_entry(r, c, IDX_W, MAG_W));
    end
  end

  always_ff @(posedge clk) begin
    if (en_i) mag_o <= rom[{row_i, col_i}];
  end
endmodule

// File: rtl/mag_seq_ctrl.sv
module mag_seq_ctrl #(
  parameter int N_PTS  = 256,
  parameter int ADDR_W = $clog2(N_PTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_en_o,
  output logic              calc_o,
  output logic              wr_en_o,
  output logic              end_bin_o,
  output logic [ADDR_W-1:0] bin_o
);
  import lsm_pkg::*;

  localparam logic [ADDR_W-1:0] HALF = ADDR_W'(N_PTS / 2);

  seq_st_t st_q, st_d;
  logic [ADDR_W-1:0] bin_q, bin_d;

  always_comb begin
    st_d  = st_q;
    bin_d = bin_q;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d  = ST_RD;
        bin_d = '0;
      end
      ST_RD:   st_d = ST_CALC;
      ST_CALC: st_d = ST_WR;
      ST_WR: begin
        if (bin_q == HALF) st_d = ST_DONE;
        else begin
          st_d  = ST_RD;
          bin_d = bin_q + 1'b1;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      bin_q <= '0;
    end else begin
      st_q  <= st_d;
      bin_q <= bin_d;
    end
  end

  assign rd_en_o   = (st_q == ST_RD);
  assign calc_o    = (st_q == ST_CALC);
  assign wr_en_o   = (st_q == ST_WR);
  assign done_o    = (st_q == ST_DONE);
  assign busy_o    = rd_en_o | calc_o | wr_en_o;
  assign bin_o     = bin_q;
  assign end_bin_o = (bin_q == '0) || (bin_q == HALF);

  AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> $past(rd_en_o, 2)); // R7
  AST_WR_SAME_BIN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> bin_o == $past(bin_o, 2)); // R7
  AST_BIN_IN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> bin_o <= HALF); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(wr_en_o) && $past(bin_o) == HALF)); // R8
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (bin_o >= $past(bin_o))); // R9
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_en_o, wr_en_o, done_o})); // R7
endmodule

// File: rtl/lut_spectrum_mag.sv
module lut_spectrum_mag #(
  parameter int N_PTS  = 256,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4,
  parameter int MAG_W  = 8,
  parameter int ADDR_W = $clog2(N_PTS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     ram_rd_en_o,
  output logic [ADDR_W-1:0]        ram_rd_addr_o,
  input  logic signed [DATA_W-1:0] ram_re_i,
  input  logic signed [DATA_W-1:0] ram_im_i,
  output logic                     ram_wr_en_o,
  output logic [ADDR_W-1:0]        ram_wr_addr_o,
  output logic [DATA_W-1:0]        ram_wr_data_o
);
  logic              calc;
  logic              end_bin;
  logic [ADDR_W-1:0] bin;
  logic [IDX_W-1:0]  row_idx, col_idx;
  logic [MAG_W-1:0]  mag_q;

  mag_seq_ctrl #(.N_PTS(N_PTS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .rd_en_o   (ram_rd_en_o),
    .calc_o    (calc),
    .wr_en_o   (ram_wr_en_o),
    .end_bin_o (end_bin),
    .bin_o     (bin)
  );

  mag_abs_index #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_re_idx (
    .val_i (ram_re_i),
    .zero_i(1'b0),
    .idx_o (row_idx)
  );

  mag_abs_index #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_im_idx (
    .val_i (ram_im_i),
    .zero_i(end_bin),
    .idx_o (col_idx)
  );

  mag_lut_rom #(.IDX_W(IDX_W), .MAG_W(MAG_W)) u_rom (
    .clk  (clk),
    .en_i (calc),
    .row_i(row_idx),
    .col_i(col_idx),
    .mag_o(mag_q)
  );

  assign ram_rd_addr_o = bin;
  assign ram_wr_addr_o = bin;
  assign ram_wr_data_o = {{(DATA_W-MAG_W){1'b0}}, mag_q};

  AST_WR_AFTER_CALC: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_en_o |-> $past(calc)); // R7
  AST_END_BIN_COL: assert property (@(posedge clk) disable iff (!rst_n)
    (calc && end_bin) |-> col_idx == '0); // R6
endmodule

// File: tb/lut_spectrum_mag_tb.sv
module lut_spectrum_mag_tb;
  localparam int N    = 16;
  localparam int AW   = 4;
  localparam int HALF = N / 2;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic busy, done, rd_en, wr_en;
  logic [AW-1:0] rd_addr, wr_addr;
  logic signed [15:0] re_q, im_q;
  logic [15:0] wr_data;

  always #2.5 clk = ~clk;

  lut_spectrum_mag #(.N_PTS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
    .ram_rd_en_o(rd_en), .ram_rd_addr_o(rd_addr), .ram_re_i(re_q), .ram_im_i(im_q),
    .ram_wr_en_o(wr_en), .ram_wr_addr_o(wr_addr), .ram_wr_data_o(wr_data)
  );

  logic signed [15:0] mem_re [N];
  logic signed [15:0] mem_im [N];
  logic signed [15:0] orig_re [N];
  logic signed [15:0] orig_im [N];

  int checks = 0, errors = 0;
  int wr_cnt = 0, done_cnt = 0, order_err = 0, gap_err = 0, cyc = 0, last_wr = 0;
  int next_addr = 0;
  bit finished = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_en) begin
      re_q <= mem_re[rd_addr];
      im_q <= mem_im[rd_addr];
    end
    if (wr_en) begin
      mem_re[wr_addr] <= wr_data;
      if (int'(wr_addr) != next_addr) order_err <= order_err + 1;
      if (wr_cnt > 0 && cyc - last_wr != 3) gap_err <= gap_err + 1;
      next_addr <= next_addr + 1;
      last_wr <= cyc;
      wr_cnt <= wr_cnt + 1;
    end
    if (done) done_cnt <= done_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int idx_of(input logic signed [15:0] v);
    int a;
    a = int'(v);
    if (a < 0) a = -a;
    if (a > 32767) a = 32767;
    return a / 2048;
  endfunction

  function automatic int exp_mag(input int i, input int j);
    int m, v;
    v = 256 * (i * i + j * j);
    m = 0;
    while ((m + 1) * (m + 1) <= v) m++;
    return (m > 255) ? 255 : m;
  endfunction

  task automatic run(input bit poke);
    int w;
    wr_cnt = 0; done_cnt = 0; order_err = 0; gap_err = 0; next_addr = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check(busy == 1'b1, "R8 busy after start", busy, 1);
    if (poke) begin
      repeat (7) @(negedge clk);
      start = 1;                      // R9 start while busy
      @(negedge clk); start = 0;
    end
    w = 0;
    while (!done && w < 200) begin @(negedge clk); w++; end
    start = 1;                        // R9 start during done cycle
    check(busy == 1'b0, "R8 busy low at done", busy, 0);
    @(negedge clk); start = 0;
    check(done == 1'b0, "R8 done single pulse", done, 0);
    repeat (3) @(negedge clk);
    check(wr_cnt == HALF + 1, "R5/R9 write count", wr_cnt, HALF + 1);
    check(done_cnt == 1, "R8/R9 done count", done_cnt, 1);
    check(order_err == 0, "R7 ascending order", order_err, 0);
    check(gap_err == 0, "R7 three-cycle spacing", gap_err, 0);
    for (int b = 0; b < N; b++) begin
      int e;
      check(mem_im[b] == orig_im[b], "R5 imaginary untouched", mem_im[b], orig_im[b]);
      if (b <= HALF) begin
        e = exp_mag(idx_of(orig_re[b]), (b == 0 || b == HALF) ? 0 : idx_of(orig_im[b]));
        check(int'(mem_re[b]) == e, (b == 0 || b == HALF) ? "R6 end bin" : "R4 magnitude",
              int'(mem_re[b]), e);
      end else begin
        check(mem_re[b] == orig_re[b], "R5 upper bin untouched", mem_re[b], orig_re[b]);
      end
    end
  endtask

  task automatic load(input int b, input logic signed [15:0] r, input logic signed [15:0] i);
    mem_re[b] = r; mem_im[b] = i; orig_re[b] = r; orig_im[b] = i;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !rd_en && !wr_en, "R1 reset idle",
          {busy, done, rd_en, wr_en}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !done && !wr_en, "R1 idle after reset", {busy, done, wr_en}, 0);
    // R2 R3 R4 sweep over every index pair
    for (int r = 0; r < 37; r++) begin
      for (int b = 0; b < N; b++) begin
        int p, i, j, lo, rv, iv;
        p = r * 7 + (b - 1);
        if (b >= 1 && b < HALF) begin
          p = p % 256;
          i = p / 16; j = p % 16;
          lo = (p * 97 + r * 13) % 2048;
          rv = i * 2048 + lo; iv = j * 2048 + ((lo * 3) % 2048);
          if (p % 3 == 1) rv = -rv;
          if (p % 2 == 1) iv = -iv;
          load(b, 16'(rv), 16'(iv));
        end else if (b == 0 || b == HALF) begin
          rv = ((r * 5 + b) % 16) * 2048 + r;
          if (r % 2 == 1) rv = -rv;
          load(b, 16'(rv), 16'((r % 15 + 1) * 2048));
        end else begin
          load(b, 16'(16'h1234 + b + r), 16'(16'h0F00 - b));
        end
      end
      run(r % 2 == 1);
    end
    // R2 most negative value saturates to index 15
    for (int b = 0; b < N; b++) load(b, 16'sd100, 16'sd0);
    load(0, -16'sd32768, 16'sd5);
    load(3, -16'sd32768, -16'sd32768);
    load(4, 16'sd32767, -16'sd32768);
    load(HALF, -16'sd32768, -16'sd32768);
    run(1'b0);
    check(int'(mem_re[0]) == 240, "R2 -32768 row", int'(mem_re[0]), 240);
    check(int'(mem_re[3]) == 255, "R2 saturated corner", int'(mem_re[3]), 255);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule